// File: doc/BRIEF.md
# Serial Register Port with Mirrored Interface Configuration

This block is a serial peripheral port that gives a host access to a byte-wide register file at 15-bit addresses. Each transfer opens with a 16-bit command word: the top bit selects read (1) or write (0) and the remaining fifteen bits give the starting address. Data bytes follow. While chip select stays low, further bytes go on streaming, and the address steps after each byte in the direction that software has chosen.

Software sets the framing of the port through the port itself. The register at address 0 holds the interface controls: bit order, step direction, whether read data leaves on a dedicated output pin (4-wire) or on the shared data pin (3-wire), and a soft reset. Each control appears twice, in bit-reversed mirror positions. A write to this register takes effect only when the two copies agree. Framing changes apply from the next chip-select assertion onward. The file also contains read-only identity bytes, a scratchpad, a bank of plain control bytes, a transfer-control register with a single-byte mode, and a status byte that is sampled from input pins.

The host side uses SPI mode 0: the clock idles low, the port samples input on the rising edge and changes output on the falling edge. All pins are oversampled by the system clock, which must run at least eight times faster than the serial clock.

Top module: `spi_mirror_regs`

## Requirements
- R1: A transfer is a 16-bit command word followed by 8-bit data bytes. Command bit 15 = 1 means read and 0 means write, and bits 14..0 give the start address. Writes commit when the eighth data bit of a byte is received. Read data is fetched after the command, and again after each byte.
- R2: Address 0x00 reads back as {srst, lsb, asc, four, four, asc, lsb, srst} from bit 7 down to bit 0. Its reset value is 0x00, which means 3-wire, MSB first, decrementing. The srst positions always read 0.
- R3: A write to address 0x00 is accepted only when data bits 7..4 equal data bits 0..3 in reverse order (bit7=bit0, bit6=bit1, bit5=bit2, bit4=bit3). Any other value leaves the register unchanged.
- R4: An accepted write to address 0x00 with bit 0 set returns every writable register to its reset value, including the framing controls.
- R5: After each data byte the address steps by +1 when asc=1 and by -1 when asc=0.
- R6: With four=1, read data appears on `sdo` and `sdio_oe` stays 0. With four=0, read data appears on `sdio_out` with `sdio_oe`=1, and `sdo` stays 0.
- R7: When lsb=1, both the command word and the data bytes are shifted least significant bit first. Framing controls are captured when chip select falls, so a new setting applies from the next transfer.
- R8: Address 0x01 stores bit 7 (single-byte mode) and bit 5; all other bits read 0. In single-byte mode each transfer covers one data byte only: later write bytes are dropped and later read bytes return 0.
- R9: Identity bytes are constant and cannot be written: 0x03 reads 0x06, 0x04 reads 0x05, 0x0C reads 0x56 and 0x0D reads 0x04.
- R10: Address 0x0A is a read/write scratchpad, and addresses 0x10..0x1F are plain read/write bytes. All of them reset to 0x00.
- R11: Address 0x49 reads {4'b0, status_in[3:0]} (bit 0 locked, bit 1 sequencer busy, bit 2 converter busy, bit 3 reference good). The value is taken at the moment the byte is fetched.
- R12: Addresses that are not implemented, including any address above 0x54, read 0x00 and ignore writes.
- R13: Raising chip select abandons any partial command or data byte without a write. The next transfer needs a fresh command word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock, idles low |
| cs_n | input | 1 | Active-low chip select |
| sdio_in | input | 1 | Serial data from the host |
| status_in | input | 4 | Live status bits shown at address 0x49 |
| sdo | output | 1 | Read data in 4-wire mode, 0 otherwise |
| sdio_out | output | 1 | Read data in 3-wire mode, 0 otherwise |
| sdio_oe | output | 1 | Output enable for the shared data pin in 3-wire mode |

## Verification
The assertions take for granted that the serial pins change slowly enough, relative to the system clock, for every edge to pass through the synchronizer as a separate event. They also assume that chip select never rises in the same oversampled cycle in which a byte completes. The stimulus holds each serial clock phase for eight system clocks and waits a full half period before it raises chip select. Every register-0 write in the stimulus uses either a matched mirror pattern or a deliberately broken one, so the soft-reset and reject properties each see both kinds of value.

// File: rtl/spi_mirror_regs_pkg.sv
package spi_mirror_regs_pkg;
  localparam int ADDR_W = 15;
  localparam int CMD_W  = 16;
  localparam int BYTE_W = 8;

  localparam logic [ADDR_W-1:0] A_IFCFG  = 15'h0000;
  localparam logic [ADDR_W-1:0] A_XFER   = 15'h0001;
  localparam logic [ADDR_W-1:0] A_TYPE   = 15'h0003;
  localparam logic [ADDR_W-1:0] A_PROD   = 15'h0004;
  localparam logic [ADDR_W-1:0] A_SCR    = 15'h000A;
  localparam logic [ADDR_W-1:0] A_VIDLO  = 15'h000C;
  localparam logic [ADDR_W-1:0] A_VIDHI  = 15'h000D;
  localparam logic [ADDR_W-1:0] A_STAT   = 15'h0049;

  localparam logic [BYTE_W-1:0] K_TYPE  = 8'h06;
  localparam logic [BYTE_W-1:0] K_PROD  = 8'h05;
  localparam logic [BYTE_W-1:0] K_VIDLO = 8'h56;
  localparam logic [BYTE_W-1:0] K_VIDHI = 8'h04;

  typedef enum logic [1:0] {PH_IDLE, PH_CMD, PH_DATA, PH_HOLD} phase_e;

  typedef struct packed {
    logic lsb_first;
    logic ascend;
    logic four_wire;
    logic single;
  } frame_cfg_t;

  function automatic logic [BYTE_W-1:0] rev8(input logic [BYTE_W-1:0] v);
    logic [BYTE_W-1:0] r;
    for (int i = 0; i < BYTE_W; i++) r[i] = v[BYTE_W-1-i];
    return r;
  endfunction

  function automatic logic [CMD_W-1:0] rev16(input logic [CMD_W-1:0] v);
    logic [CMD_W-1:0] r;
    for (int i = 0; i < CMD_W; i++) r[i] = v[CMD_W-1-i];
    return r;
  endfunction
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  input  logic mosi,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic cs_fall,
  output logic cs_rise,
  output logic mosi_s
);
  logic [STAGES-1:0] sclk_sh, cs_sh, mosi_sh;
  logic              sclk_d, cs_d;
  logic              sclk_s, cs_s;

  assign sclk_s = sclk_sh[STAGES-1];
  assign cs_s   = cs_sh[STAGES-1];
  assign mosi_s = mosi_sh[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_sh <= '0;
      cs_sh   <= '1;
      mosi_sh <= '0;
      sclk_d  <= 1'b0;
      cs_d    <= 1'b1;
    end else begin
      sclk_sh <= {sclk_sh[STAGES-2:0], sclk};
      cs_sh   <= {cs_sh[STAGES-2:0], cs_n};
      mosi_sh <= {mosi_sh[STAGES-2:0], mosi};
      sclk_d  <= sclk_s;
      cs_d    <= cs_s;
    end
  end

  assign sclk_rise = sclk_s & ~sclk_d & ~cs_s;
  assign sclk_fall = ~sclk_s & sclk_d & ~cs_s;
  assign cs_fall   = ~cs_s & cs_d;
  assign cs_rise   = cs_s & ~cs_d;
endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine
  import spi_mirror_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              cs_fall,
  input  logic              cs_rise,
  input  logic              mosi_s,
  input  frame_cfg_t        cfg_in,
  input  logic [BYTE_W-1:0] rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              out_bit,
  output logic              out_active,
  output logic              four_wire,
  output logic              hold
);
  localparam int CNT_W = $clog2(CMD_W);

  phase_e            phase_q, phase_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [CMD_W-1:0]  rx_q, rx_n, rx_word, cmd_word;
  logic [BYTE_W-1:0] byte_word;
  logic [ADDR_W-1:0] addr_q, addr_n, addr_step;
  logic              is_rd_q, is_rd_n;
  frame_cfg_t        cfg_q, cfg_n;
  logic [BYTE_W-1:0] tx_q, tx_n;
  logic              out_q, out_n;
  logic              load_q, load_n;
  logic              wr_en_q, wr_en_n;
  logic [ADDR_W-1:0] wr_addr_q, wr_addr_n;
  logic [BYTE_W-1:0] wr_data_q, wr_data_n;

  assign rx_word   = {rx_q[CMD_W-2:0], mosi_s};
  assign cmd_word  = cfg_q.lsb_first ? rev16(rx_word) : rx_word;
  assign byte_word = cfg_q.lsb_first ? rev8(rx_word[BYTE_W-1:0]) : rx_word[BYTE_W-1:0];
  assign addr_step = cfg_q.ascend ? addr_q + 1'b1 : addr_q - 1'b1;

  always_comb begin
    phase_n   = phase_q;
    cnt_n     = cnt_q;
    rx_n      = rx_q;
    addr_n    = addr_q;
    is_rd_n   = is_rd_q;
    cfg_n     = cfg_q;
    tx_n      = tx_q;
    out_n     = out_q;
    load_n    = 1'b0;
    wr_en_n   = 1'b0;
    wr_addr_n = wr_addr_q;
    wr_data_n = wr_data_q;
    if (cs_rise) begin
      phase_n = PH_IDLE;
    end else if (cs_fall) begin
      phase_n = PH_CMD;
      cnt_n   = '0;
      cfg_n   = cfg_in;
      out_n   = 1'b0;
    end else if (sclk_rise) begin
      case (phase_q)
        PH_CMD: begin
          rx_n  = rx_word;
          cnt_n = cnt_q + 1'b1;
          if (cnt_q == CNT_W'(CMD_W-1)) begin
            phase_n = PH_DATA;
            cnt_n   = '0;
            is_rd_n = cmd_word[CMD_W-1];
            addr_n  = cmd_word[ADDR_W-1:0];
            load_n  = cmd_word[CMD_W-1];
          end
        end
        PH_DATA: begin
          rx_n  = rx_word;
          cnt_n = cnt_q + 1'b1;
          if (cnt_q == CNT_W'(BYTE_W-1)) begin
            cnt_n = '0;
            if (!is_rd_q) begin
              wr_en_n   = 1'b1;
              wr_addr_n = addr_q;
              wr_data_n = byte_word;
            end
            if (cfg_q.single) begin
              phase_n = PH_HOLD;
            end else begin
              addr_n = addr_step;
              load_n = is_rd_q;
            end
          end
        end
        default: ;
      endcase
    end else if (sclk_fall && phase_q == PH_DATA && is_rd_q) begin
      out_n = tx_q[BYTE_W-1];
      tx_n  = {tx_q[BYTE_W-2:0], 1'b0};
    end
    if (load_q) begin
      tx_n = cfg_q.lsb_first ? rev8(rd_data) : rd_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      cnt_q     <= '0;
      rx_q      <= '0;
      addr_q    <= '0;
      is_rd_q   <= 1'b0;
      cfg_q     <= '0;
      tx_q      <= '0;
      out_q     <= 1'b0;
      load_q    <= 1'b0;
      wr_en_q   <= 1'b0;
      wr_addr_q <= '0;
      wr_data_q <= '0;
    end else begin
      phase_q   <= phase_n;
      cnt_q     <= cnt_n;
      rx_q      <= rx_n;
      addr_q    <= addr_n;
      is_rd_q   <= is_rd_n;
      cfg_q     <= cfg_n;
      tx_q      <= tx_n;
      out_q     <= out_n;
      load_q    <= load_n;
      wr_en_q   <= wr_en_n;
      wr_addr_q <= wr_addr_n;
      wr_data_q <= wr_data_n;
    end
  end

  assign rd_addr    = addr_q;
  assign wr_en      = wr_en_q;
  assign wr_addr    = wr_addr_q;
  assign wr_data    = wr_data_q;
  assign out_bit    = out_q;
  assign out_active = (phase_q == PH_DATA) && is_rd_q;
  assign four_wire  = cfg_q.four_wire;
  assign hold       = (phase_q == PH_HOLD);
endmodule

// File: rtl/spi_reg_store.sv
module spi_reg_store
  import spi_mirror_regs_pkg::*;
#(
  parameter int BANK_BASE  = 16,
  parameter int BANK_DEPTH = 16,
  parameter int STAT_W     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [STAT_W-1:0] status_in,
  output logic [BYTE_W-1:0] rd_data,
  output frame_cfg_t        cfg_out
);
  localparam int BANK_IW = (BANK_DEPTH > 1) ? $clog2(BANK_DEPTH) : 1;

  frame_cfg_t        cfg_q, cfg_n;
  logic              aux_q, aux_n;
  logic [BYTE_W-1:0] scr_q, scr_n;
  logic [BYTE_W-1:0] bank_q [BANK_DEPTH];
  logic [BYTE_W-1:0] bank_n [BANK_DEPTH];
  logic [BANK_DEPTH-1:0] bank_we;
  logic [STAT_W-1:0] stat_q;
  logic              mirror_ok, soft_rst;
  logic [ADDR_W-1:0] bank_off;
  logic              bank_hit;

  assign mirror_ok = (wr_data[7:4] == {wr_data[0], wr_data[1], wr_data[2], wr_data[3]});
  assign soft_rst  = wr_en && (wr_addr == A_IFCFG) && mirror_ok && wr_data[0];

  for (genvar g = 0; g < BANK_DEPTH; g++) begin : g_bank_dec
    assign bank_we[g] = (wr_addr == ADDR_W'(BANK_BASE + g));
  end

  always_comb begin
    cfg_n = cfg_q;
    aux_n = aux_q;
    scr_n = scr_q;
    for (int i = 0; i < BANK_DEPTH; i++) bank_n[i] = bank_q[i];
    if (soft_rst) begin
      cfg_n = '0;
      aux_n = 1'b0;
      scr_n = '0;
      for (int i = 0; i < BANK_DEPTH; i++) bank_n[i] = '0;
    end else if (wr_en) begin
      if (wr_addr == A_IFCFG && mirror_ok) begin
        cfg_n.lsb_first = wr_data[1];
        cfg_n.ascend    = wr_data[2];
        cfg_n.four_wire = wr_data[3];
      end
      if (wr_addr == A_XFER) begin
        cfg_n.single = wr_data[7];
        aux_n        = wr_data[5];
      end
      if (wr_addr == A_SCR) scr_n = wr_data;
      for (int i = 0; i < BANK_DEPTH; i++) begin
        if (bank_we[i]) bank_n[i] = wr_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      aux_q  <= 1'b0;
      scr_q  <= '0;
      stat_q <= '0;
      for (int i = 0; i < BANK_DEPTH; i++) bank_q[i] <= '0;
    end else begin
      cfg_q  <= cfg_n;
      aux_q  <= aux_n;
      scr_q  <= scr_n;
      stat_q <= status_in;
      for (int i = 0; i < BANK_DEPTH; i++) bank_q[i] <= bank_n[i];
    end
  end

  assign bank_off = rd_addr - ADDR_W'(BANK_BASE);
  assign bank_hit = (rd_addr >= ADDR_W'(BANK_BASE)) &&
                    (rd_addr < ADDR_W'(BANK_BASE + BANK_DEPTH));

  always_comb begin
    rd_data = '0;
    if (bank_hit) begin
      rd_data = bank_q[bank_off[BANK_IW-1:0]];
    end else begin
      case (rd_addr)
        A_IFCFG: rd_data = {1'b0, cfg_q.lsb_first, cfg_q.ascend, cfg_q.four_wire,
                            cfg_q.four_wire, cfg_q.ascend, cfg_q.lsb_first, 1'b0};
        A_XFER:  rd_data = {cfg_q.single, 1'b0, aux_q, 5'b0};
        A_TYPE:  rd_data = K_TYPE;
        A_PROD:  rd_data = K_PROD;
        A_SCR:   rd_data = scr_q;
        A_VIDLO: rd_data = K_VIDLO;
        A_VIDHI: rd_data = K_VIDHI;
        A_STAT:  rd_data = BYTE_W'(stat_q);
        default: rd_data = '0;
      endcase
    end
  end

  assign cfg_out = cfg_q;
endmodule

// File: rtl/spi_mirror_regs.sv
module spi_mirror_regs
  import spi_mirror_regs_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int BANK_BASE   = 16,
  parameter int BANK_DEPTH  = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclk,
  input  logic       cs_n,
  input  logic       sdio_in,
  input  logic [3:0] status_in,
  output logic       sdo,
  output logic       sdio_out,
  output logic       sdio_oe
);
  logic              sclk_rise, sclk_fall, cs_fall, cs_rise, mosi_s;
  logic [ADDR_W-1:0] rf_rd_addr, rf_wr_addr;
  logic [BYTE_W-1:0] rf_rd_data, rf_wr_data;
  logic              rf_wr_en;
  frame_cfg_t        rf_cfg;
  logic              eng_bit, eng_active, eng_four, eng_hold;

  spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(sdio_in),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .cs_fall(cs_fall), .cs_rise(cs_rise), .mosi_s(mosi_s)
  );

  spi_frame_engine u_eng (
    .clk(clk), .rst_n(rst_n),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .cs_fall(cs_fall), .cs_rise(cs_rise), .mosi_s(mosi_s),
    .cfg_in(rf_cfg), .rd_data(rf_rd_data), .rd_addr(rf_rd_addr),
    .wr_en(rf_wr_en), .wr_addr(rf_wr_addr), .wr_data(rf_wr_data),
    .out_bit(eng_bit), .out_active(eng_active), .four_wire(eng_four),
    .hold(eng_hold)
  );

  spi_reg_store #(.BANK_BASE(BANK_BASE), .BANK_DEPTH(BANK_DEPTH), .STAT_W(4)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .wr_en(rf_wr_en), .wr_addr(rf_wr_addr), .wr_data(rf_wr_data),
    .rd_addr(rf_rd_addr), .status_in(status_in),
    .rd_data(rf_rd_data), .cfg_out(rf_cfg)
  );

  assign sdo      = (eng_active && eng_four) ? eng_bit : 1'b0;
  assign sdio_oe  = eng_active && !eng_four;
  assign sdio_out = sdio_oe ? eng_bit : 1'b0;
endmodule

// File: rtl/spi_mirror_regs_chk.sv
module spi_mirror_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [14:0] wr_addr,
  input logic [7:0]  wr_data,
  input logic [3:0]  cfg,
  input logic        hold,
  input logic        sdo,
  input logic        sdio_oe
);
  logic mirror_match;
  assign mirror_match = (wr_data[7:4] == {wr_data[0], wr_data[1], wr_data[2], wr_data[3]});

  // R4
  soft_reset_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 15'h0 && mirror_match && wr_data[0]) |=> (cfg == 4'h0));

  // R3
  bad_mirror_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 15'h0 && !mirror_match) |=> $stable(cfg));

  // R8
  hold_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && $past(hold)) |-> !wr_en);

  // R6
  one_pin_driven_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sdio_oe |-> !sdo);

  // R6
  sdo_quiet_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> (!sdo && !sdio_oe));
endmodule

bind spi_mirror_regs spi_mirror_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(rf_wr_en), .wr_addr(rf_wr_addr),
  .wr_data(rf_wr_data), .cfg(rf_cfg), .hold(eng_hold),
  .sdo(sdo), .sdio_oe(sdio_oe)
);

// File: tb/spi_mirror_regs_tb.sv
module spi_mirror_regs_tb;
  localparam int HALF = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sclk = 1'b0;
  logic       cs_n = 1'b1;
  logic       sdio_in = 1'b0;
  logic [3:0] status_in = 4'h0;
  logic       sdo, sdio_out, sdio_oe;

  int vectors = 0;
  int fails = 0;
  bit lsb_m = 1'b0;
  bit w3_m = 1'b1;
  bit single_m = 1'b0;
  logic [7:0] wbuf [8];
  logic [7:0] exp_q [$];
  string      tag_q [$];
  logic [7:0] got_q [$];

  always #2.5 clk = ~clk;

  spi_mirror_regs u_dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdio_in(sdio_in),
    .status_in(status_in), .sdo(sdo), .sdio_out(sdio_out), .sdio_oe(sdio_oe)
  );

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic expect_byte(input logic [7:0] v, input string tag);
    exp_q.push_back(v);
    tag_q.push_back(tag);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (got_q.size() > 0) begin
      logic [7:0] g;
      g = got_q.pop_front();
      if (exp_q.size() == 0) begin
        check("scoreboard-underflow", g, 8'hxx);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, g, e);
      end
    end
  end

  task automatic half_wait();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic spi_txn(input bit rd, input logic [14:0] a, input int nbytes, input string tag);
    logic [15:0] w;
    w = {rd, a};
    cs_n = 1'b0;
    half_wait();
    for (int i = 0; i < 16; i++) begin
      sdio_in = lsb_m ? w[i] : w[15-i];
      half_wait();
      sclk = 1'b1;
      half_wait();
      sclk = 1'b0;
    end
    for (int b = 0; b < nbytes; b++) begin
      logic [7:0] got;
      bit pin_bad;
      got = 8'h00;
      pin_bad = 1'b0;
      for (int i = 0; i < 8; i++) begin
        int bi;
        bi = lsb_m ? i : 7 - i;
        sdio_in = rd ? 1'b0 : wbuf[b][bi];
        half_wait();
        if (rd) begin
          got[bi] = w3_m ? sdio_out : sdo;
          if (w3_m && (sdo !== 1'b0 || (sdio_oe !== 1'b1 && !(single_m && b > 0)))) pin_bad = 1'b1;
          if (!w3_m && sdio_oe !== 1'b0) pin_bad = 1'b1;
        end
        sclk = 1'b1;
        half_wait();
        sclk = 1'b0;
      end
      if (rd) begin
        got_q.push_back(got);
        check({"R6 pin select ", tag}, {7'd0, pin_bad}, 8'h00);
      end
    end
    half_wait();
    cs_n = 1'b1;
    half_wait();
    half_wait();
  endtask

  task automatic wr1(input logic [14:0] a, input logic [7:0] d, input string tag);
    wbuf[0] = d;
    spi_txn(1'b0, a, 1, tag);
  endtask

  task automatic rd1(input logic [14:0] a, input logic [7:0] e, input string tag);
    expect_byte(e, tag);
    spi_txn(1'b1, a, 1, tag);
  endtask

  task automatic spi_abort(input logic [14:0] a, input int nbits);
    logic [15:0] w;
    w = {1'b0, a};
    cs_n = 1'b0;
    half_wait();
    for (int i = 0; i < nbits; i++) begin
      sdio_in = (i < 16) ? (lsb_m ? w[i] : w[15-i]) : 1'b1;
      half_wait();
      sclk = 1'b1;
      half_wait();
      sclk = 1'b0;
    end
    half_wait();
    cs_n = 1'b1;
    half_wait();
    half_wait();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    vectors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R6 idle outputs", {6'd0, sdo, sdio_oe}, 8'h00);

    // R2 reset value, R1 basic read, R9 identity, 3-wire at reset
    rd1(15'h0000, 8'h00, "R2 reset cfg");
    rd1(15'h0003, 8'h06, "R9 chip type");
    rd1(15'h0001, 8'h00, "R8 xfer reset");

    // R2 mirrored readback after switching to 4-wire, incrementing
    wr1(15'h0000, 8'h3C, "R2 cfg write");
    w3_m = 1'b0;
    rd1(15'h0000, 8'h3C, "R2 mirror readback");

    // R3 broken mirror ignored
    wr1(15'h0000, 8'h08, "R3 bad mirror");
    rd1(15'h0000, 8'h3C, "R3 cfg unchanged");

    // R10 scratchpad and bank; R5 ascending stream
    wr1(15'h000A, 8'hA5, "R10 scratch write");
    rd1(15'h000A, 8'hA5, "R10 scratch read");
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
    spi_txn(1'b0, 15'h0010, 4, "R5 ascending write");
    expect_byte(8'h11, "R5 asc read 0x10");
    expect_byte(8'h22, "R5 asc read 0x11");
    expect_byte(8'h33, "R5 asc read 0x12");
    expect_byte(8'h44, "R5 asc read 0x13");
    spi_txn(1'b1, 15'h0010, 4, "R5 ascending read");
    rd1(15'h001F, 8'h00, "R10 bank reset value");

    // R9 identity stream and read-only
    expect_byte(8'h56, "R9 vendor lo");
    expect_byte(8'h04, "R9 vendor hi");
    spi_txn(1'b1, 15'h000C, 2, "R9 stream");
    wr1(15'h0003, 8'hFF, "R9 write chip type");
    rd1(15'h0003, 8'h06, "R9 chip type unchanged");
    rd1(15'h0004, 8'h05, "R9 product id");

    // R12 unimplemented
    wr1(15'h0020, 8'h77, "R12 write hole");
    rd1(15'h0020, 8'h00, "R12 hole reads zero");
    rd1(15'h0055, 8'h00, "R12 beyond top");
    rd1(15'h0054, 8'h00, "R12 top address");

    // R5 descending
    wr1(15'h0000, 8'h18, "R5 set descend");
    expect_byte(8'h04, "R5 desc 0x0D");
    expect_byte(8'h56, "R5 desc 0x0C");
    expect_byte(8'h00, "R5 desc 0x0B");
    spi_txn(1'b1, 15'h000D, 3, "R5 descending read");
    wbuf[0] = 8'hAA; wbuf[1] = 8'hBB;
    spi_txn(1'b0, 15'h0013, 2, "R5 descending write");
    expect_byte(8'hAA, "R5 desc 0x13");
    expect_byte(8'hBB, "R5 desc 0x12");
    spi_txn(1'b1, 15'h0013, 2, "R5 descending readback");

    // R7 LSB-first
    wr1(15'h0000, 8'h7E, "R7 set lsb first");
    lsb_m = 1'b1;
    rd1(15'h000A, 8'hA5, "R7 lsb read scratch");
    rd1(15'h0000, 8'h7E, "R7 lsb read cfg");
    wr1(15'h000A, 8'h3C, "R7 lsb write scratch");
    rd1(15'h000A, 8'h3C, "R7 lsb readback");
    wr1(15'h0000, 8'h3C, "R7 back to msb");
    lsb_m = 1'b0;
    rd1(15'h0000, 8'h3C, "R7 msb restored");

    // R8 single-byte mode
    wr1(15'h0001, 8'hA0, "R8 set single");
    single_m = 1'b1;
    rd1(15'h0001, 8'hA0, "R8 xfer readback");
    wbuf[0] = 8'h55; wbuf[1] = 8'h66;
    spi_txn(1'b0, 15'h0014, 2, "R8 single write");
    expect_byte(8'h55, "R8 first byte");
    expect_byte(8'h00, "R8 second byte held");
    spi_txn(1'b1, 15'h0014, 2, "R8 single read");
    rd1(15'h0015, 8'h00, "R8 second write dropped");
    wr1(15'h0001, 8'h00, "R8 clear single");
    single_m = 1'b0;
    expect_byte(8'hAA, "R8 stream restored 0x13");
    expect_byte(8'h55, "R8 stream restored 0x14");
    spi_txn(1'b1, 15'h0013, 2, "R8 stream read");

    // R11 status
    status_in = 4'hA;
    rd1(15'h0049, 8'h0A, "R11 status A");
    status_in = 4'h5;
    rd1(15'h0049, 8'h05, "R11 status 5");

    // R13 abort
    spi_abort(15'h000A, 20);
    rd1(15'h000A, 8'h3C, "R13 partial data no write");
    spi_abort(15'h000A, 7);
    rd1(15'h000C, 8'h56, "R13 fresh command after abort");

    // R4 soft reset
    wr1(15'h0000, 8'hBD, "R4 soft reset");
    w3_m = 1'b1;
    rd1(15'h0000, 8'h00, "R4 cfg cleared");
    rd1(15'h000A, 8'h00, "R4 scratch cleared");
    rd1(15'h0014, 8'h00, "R4 bank cleared");
    rd1(15'h0003, 8'h06, "R4 identity kept");

    repeat (20) @(negedge clk);
    if (exp_q.size() != 0) check("scoreboard-leftover", 8'(exp_q.size()), 8'h00);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule